// File: doc/BRIEF.md
# Bus-Addressed Dual GPIO with RAM

This block is the host-facing decoder of a combined memory and general-purpose I/O peripheral. A processor-style bus selects it with two chip selects of opposite polarity. A separate active-low memory-select line divides its address space into two halves. With memory-select low, the seven address bits reach a 128-byte scratch RAM. With memory-select high, the low address bits reach two 8-bit bidirectional ports. Each port has an output-value register and a direction register.

Pins whose direction bit is set drive the stored output value. All other pins are inputs. Pin levels pass through a two-flop synchronizer before the bus can read them. Accesses with memory-select high and address bit 2 set belong to a sibling timer/interrupt block. They are flagged on `aux_sel`, and that block's read data is returned on the bus.

Read data is combinational from the current address. A write takes effect on the rising clock edge.

Top module: `gpio_ram_bus`

## Requirements
- R1: The block is selected only when `sel_act_hi`=1 and `sel_act_lo_n`=0. When it is not selected, no register or RAM byte changes, `rdata_oe` is 0 and `aux_sel` is 0.
- R2: When selected with `mem_sel_n`=0, `addr[6:0]` picks one of 128 RAM bytes. `rnw`=0 writes `wdata` into that byte at the rising edge. `rnw`=1 returns that byte on `rdata` in the same cycle.
- R3: When selected with `mem_sel_n`=1 and `addr[2]`=0, `addr[1:0]` picks a register: 00 is port 0 output, 01 is port 0 direction, 10 is port 1 output, 11 is port 1 direction. `addr[6:3]` is ignored. A read at 01 or 11 returns the direction register.
- R4: Each pin's output enable equals its direction bit (1 = output, 0 = input). Each pin's output value equals the stored output-register bit.
- R5: A read at 00 or 10 returns that port's pin levels as they were two rising edges earlier. A pin change is not visible after only one edge.
- R6: While `rst_n` is 0, both output registers and both direction registers are cleared, so every pin is an input. `rdata_oe` is 0 during reset.
- R7: `rdata_oe` is 1 exactly during a selected read (`rnw`=1). It is 0 during writes and when the block is not selected. `rdata` is 0 whenever `rdata_oe` is 0.
- R8: Reset leaves the RAM contents unchanged.
- R9: When selected with `mem_sel_n`=1 and `addr[2]`=1, `aux_sel` is 1. A read returns `aux_rdata`. A write changes no port register.
- R10: A selected cycle with `rnw`=1 changes no register, even when `wdata` carries a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_act_hi | input | 1 | Chip select, active high |
| sel_act_lo_n | input | 1 | Chip select, active low |
| mem_sel_n | input | 1 | 0 selects RAM, 1 selects registers |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 7 | Byte or register address |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Read data to the host |
| rdata_oe | output | 1 | Data-bus drive enable |
| aux_sel | output | 1 | Access belongs to the timer/interrupt sibling |
| aux_rdata | input | 8 | Read data from the sibling |
| port0_pin_in | input | 8 | Port 0 pin levels |
| port0_pin_out | output | 8 | Port 0 drive values |
| port0_pin_oe | output | 8 | Port 0 drive enables |
| port1_pin_in | input | 8 | Port 1 pin levels |
| port1_pin_out | output | 8 | Port 1 drive values |
| port1_pin_oe | output | 8 | Port 1 drive enables |

## Verification
The properties take for granted that the bus inputs are stable between clock edges. They also assume reset is released away from a rising edge. The bench meets both assumptions by changing every input only on the falling edge.

The hold property covers port registers and pins. It assumes the only writer is a selected cycle with `rnw` low. The bench therefore exercises reads carrying stray write data, unselected writes and sibling-region writes, to show that none of them disturbs a pin.

Pin stimulus changes on a falling edge. Sampling then relies on exactly two rising edges of synchronizer delay.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int RAM_DEPTH = 1 << ADDR_W;
    localparam int NUM_PORTS = 2;
    localparam int PORT_IDX_W = $clog2(NUM_PORTS);

    typedef enum logic [1:0] {
        REGION_NONE = 2'd0,
        REGION_RAM  = 2'd1,
        REGION_IO   = 2'd2,
        REGION_AUX  = 2'd3
    } region_e;

    typedef struct packed {
        region_e               region;
        logic                  wr;
        logic                  rd;
        logic [PORT_IDX_W-1:0] port_idx;
        logic                  is_dir;
    } decode_t;

    typedef struct packed {
        logic [DATA_W-1:0] out_val;
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] sync1;
        logic [DATA_W-1:0] sync2;
    } port_state_t;
endpackage

// File: rtl/gpr_decode.sv
module gpr_decode
    import gpr_pkg::*;
(
    input  logic              sel_act_hi,
    input  logic              sel_act_lo_n,
    input  logic              mem_sel_n,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    logic selected;

    always_comb begin
        selected     = sel_act_hi & ~sel_act_lo_n;
        dec          = '0;
        dec.region   = REGION_NONE;
        dec.port_idx = addr[1 +: PORT_IDX_W];
        dec.is_dir   = addr[0];
        if (selected) begin
            dec.wr = ~rnw;
            dec.rd = rnw;
            if (!mem_sel_n) begin
                dec.region = REGION_RAM;
            end else if (!addr[2]) begin
                dec.region = REGION_IO;
            end else begin
                dec.region = REGION_AUX;
            end
        end
    end
endmodule

// File: rtl/gpr_ram.sv
module gpr_ram
    import gpr_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    // Storage carries no reset so its contents survive a reset.
    logic [DATA_W-1:0] mem_q [RAM_DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/gpr_port.sv
module gpr_port
    import gpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_out,
    input  logic              wr_dir,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] dir_val,
    output logic [DATA_W-1:0] pin_level
);
    port_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = pin_in;
        st_d.sync2 = st_q.sync1;
        if (wr_out) begin
            st_d.out_val = wdata;
        end
        if (wr_dir) begin
            st_d.dir = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out   = st_q.out_val;
    assign pin_oe    = st_q.dir;
    assign dir_val   = st_q.dir;
    assign pin_level = st_q.sync2;
endmodule

// File: rtl/gpio_ram_bus.sv
module gpio_ram_bus
    import gpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_act_hi,
    input  logic              sel_act_lo_n,
    input  logic              mem_sel_n,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              aux_sel,
    input  logic [DATA_W-1:0] aux_rdata,
    input  logic [DATA_W-1:0] port0_pin_in,
    output logic [DATA_W-1:0] port0_pin_out,
    output logic [DATA_W-1:0] port0_pin_oe,
    input  logic [DATA_W-1:0] port1_pin_in,
    output logic [DATA_W-1:0] port1_pin_out,
    output logic [DATA_W-1:0] port1_pin_oe
);
    decode_t           dec;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] pin_in_a   [NUM_PORTS];
    logic [DATA_W-1:0] pin_out_a  [NUM_PORTS];
    logic [DATA_W-1:0] pin_oe_a   [NUM_PORTS];
    logic [DATA_W-1:0] dir_a      [NUM_PORTS];
    logic [DATA_W-1:0] level_a    [NUM_PORTS];

    gpr_decode u_decode (
        .sel_act_hi   (sel_act_hi),
        .sel_act_lo_n (sel_act_lo_n),
        .mem_sel_n    (mem_sel_n),
        .rnw          (rnw),
        .addr         (addr),
        .dec          (dec)
    );

    gpr_ram u_ram (
        .clk   (clk),
        .we    (dec.wr && dec.region == REGION_RAM),
        .addr  (addr),
        .wdata (wdata),
        .rdata (ram_rdata)
    );

    assign pin_in_a[0]   = port0_pin_in;
    assign pin_in_a[1]   = port1_pin_in;
    assign port0_pin_out = pin_out_a[0];
    assign port0_pin_oe  = pin_oe_a[0];
    assign port1_pin_out = pin_out_a[1];
    assign port1_pin_oe  = pin_oe_a[1];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = dec.wr && dec.region == REGION_IO
                     && dec.port_idx == PORT_IDX_W'(p);
        gpr_port u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_out    (hit && !dec.is_dir),
            .wr_dir    (hit && dec.is_dir),
            .wdata     (wdata),
            .pin_in    (pin_in_a[p]),
            .pin_out   (pin_out_a[p]),
            .pin_oe    (pin_oe_a[p]),
            .dir_val   (dir_a[p]),
            .pin_level (level_a[p])
        );
    end

    always_comb begin
        rdata_oe = dec.rd && rst_n;
        aux_sel  = dec.region == REGION_AUX;
        rdata    = '0;
        if (rdata_oe) begin
            unique case (dec.region)
                REGION_RAM: rdata = ram_rdata;
                REGION_IO:  rdata = dec.is_dir ? dir_a[dec.port_idx]
                                               : level_a[dec.port_idx];
                REGION_AUX: rdata = aux_rdata;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_ram_bus_checker.sv
module gpio_ram_bus_checker
    import gpr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sel_act_hi,
    input logic              sel_act_lo_n,
    input logic              mem_sel_n,
    input logic              rnw,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input logic              aux_sel,
    input logic [DATA_W-1:0] port0_pin_out,
    input logic [DATA_W-1:0] port0_pin_oe,
    input logic [DATA_W-1:0] port1_pin_out,
    input logic [DATA_W-1:0] port1_pin_oe
);
    logic sel;
    assign sel = sel_act_hi && !sel_act_lo_n;

    p_unsel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (!rdata_oe && !aux_sel));

    p_read_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rnw) |-> rdata_oe);

    p_idle_bus_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));

    p_write_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rnw |-> !rdata_oe);

    p_reset_inputs_r6: assert property (@(posedge clk)
        !rst_n |=> (port0_pin_oe == '0 && port1_pin_oe == '0));

    p_hold_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !rnw) |=> ($stable(port0_pin_oe) && $stable(port0_pin_out)
                            && $stable(port1_pin_oe) && $stable(port1_pin_out)));

    p_aux_no_touch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !rnw && mem_sel_n && addr[2]) |=>
            ($stable(port0_pin_oe) && $stable(port0_pin_out)
             && $stable(port1_pin_oe) && $stable(port1_pin_out)));
endmodule

bind gpio_ram_bus gpio_ram_bus_checker u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_act_hi    (sel_act_hi),
    .sel_act_lo_n  (sel_act_lo_n),
    .mem_sel_n     (mem_sel_n),
    .rnw           (rnw),
    .addr          (addr),
    .rdata         (rdata),
    .rdata_oe      (rdata_oe),
    .aux_sel       (aux_sel),
    .port0_pin_out (port0_pin_out),
    .port0_pin_oe  (port0_pin_oe),
    .port1_pin_out (port1_pin_out),
    .port1_pin_oe  (port1_pin_oe)
);

// File: tb/gpio_ram_bus_bench.sv
module gpio_ram_bus_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_act_hi = 1'b0;
    logic       sel_act_lo_n = 1'b1;
    logic       mem_sel_n = 1'b1;
    logic       rnw = 1'b1;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic       aux_sel;
    logic [7:0] aux_rdata = 8'h6B;
    logic [7:0] p0_in = '0, p1_in = '0;
    logic [7:0] p0_out, p0_oe, p1_out, p1_oe;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    gpio_ram_bus u_gpio_ram_bus (
        .clk(clk), .rst_n(rst_n), .sel_act_hi(sel_act_hi), .sel_act_lo_n(sel_act_lo_n),
        .mem_sel_n(mem_sel_n), .rnw(rnw), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .aux_sel(aux_sel), .aux_rdata(aux_rdata),
        .port0_pin_in(p0_in), .port0_pin_out(p0_out), .port0_pin_oe(p0_oe),
        .port1_pin_in(p1_in), .port1_pin_out(p1_out), .port1_pin_oe(p1_oe)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic idle();
        sel_act_hi = 1'b0; sel_act_lo_n = 1'b1; rnw = 1'b1; wdata = '0;
    endtask

    task automatic bus_write(input logic ms_n, input logic [6:0] a, input logic [7:0] d,
                             input logic hi = 1'b1, input logic lo_n = 1'b0);
        @(negedge clk);
        sel_act_hi = hi; sel_act_lo_n = lo_n; mem_sel_n = ms_n; rnw = 1'b0;
        addr = a; wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic bus_read(input logic ms_n, input logic [6:0] a, output logic [7:0] d,
                            output logic oe);
        @(negedge clk);
        sel_act_hi = 1'b1; sel_act_lo_n = 1'b0; mem_sel_n = ms_n; rnw = 1'b1; addr = a;
        #1;
        d = rdata; oe = rdata_oe;
        idle();
    endtask

    task automatic t_reset_state();
        check("R6 port0 oe after reset", p0_oe, 8'h00);
        check("R6 port1 oe after reset", p1_oe, 8'h00);
        check("R6 rdata_oe after reset", {7'd0, rdata_oe}, 8'h00);
    endtask

    task automatic t_ram();
        logic [7:0] d; logic oe;
        bus_write(1'b0, 7'h00, 8'hA5);
        bus_write(1'b0, 7'h7F, 8'h3C);
        bus_write(1'b0, 7'h55, 8'h96);
        bus_read(1'b0, 7'h00, d, oe); check("R2 ram byte 0", d, 8'hA5);
        check("R7 oe on selected read", {7'd0, oe}, 8'h01);
        bus_read(1'b0, 7'h7F, d, oe); check("R2 ram byte 127", d, 8'h3C);
        bus_read(1'b0, 7'h55, d, oe); check("R2 ram byte 0x55", d, 8'h96);
        check("R4 ram write leaves pins", p0_oe, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d; logic oe;
        bus_write(1'b1, 7'h00, 8'h3C);
        bus_write(1'b1, 7'h01, 8'hF0);
        bus_write(1'b1, 7'h02, 8'h81);
        bus_write(1'b1, 7'h03, 8'h0F);
        check("R4 port0 out", p0_out, 8'h3C);
        check("R4 port0 oe", p0_oe, 8'hF0);
        check("R4 port1 out", p1_out, 8'h81);
        check("R4 port1 oe", p1_oe, 8'h0F);
        bus_read(1'b1, 7'h01, d, oe); check("R3 read port0 dir", d, 8'hF0);
        bus_read(1'b1, 7'h03, d, oe); check("R3 read port1 dir", d, 8'h0F);
        bus_write(1'b1, 7'h79, 8'h12);
        bus_read(1'b1, 7'h01, d, oe); check("R3 upper address bits ignored", d, 8'h12);
        check("R3 port1 untouched by port0 write", p1_oe, 8'h0F);
    endtask

    task automatic t_sync();
        logic [7:0] d; logic oe;
        @(negedge clk); p0_in = 8'hC3; p1_in = 8'h5A;
        bus_read(1'b1, 7'h00, d, oe); check("R5 one edge shows old level", d, 8'h00);
        bus_read(1'b1, 7'h00, d, oe); check("R5 port0 level after two edges", d, 8'hC3);
        bus_read(1'b1, 7'h02, d, oe); check("R5 port1 level", d, 8'h5A);
    endtask

    task automatic t_select();
        logic [7:0] d; logic oe;
        bus_write(1'b1, 7'h01, 8'hEE, 1'b0, 1'b0);
        bus_write(1'b1, 7'h01, 8'hEE, 1'b1, 1'b1);
        bus_read(1'b1, 7'h01, d, oe); check("R1 unselected writes ignored", d, 8'h12);
        @(negedge clk);
        sel_act_hi = 1'b1; sel_act_lo_n = 1'b1; rnw = 1'b1; mem_sel_n = 1'b0; #1;
        check("R1 no drive when cs low not asserted", {7'd0, rdata_oe}, 8'h00);
        check("R7 rdata zero while undriven", rdata, 8'h00);
        idle();
        @(negedge clk);
        sel_act_hi = 1'b1; sel_act_lo_n = 1'b0; rnw = 1'b0; mem_sel_n = 1'b1; addr = 7'h05; #1;
        check("R7 no drive during write", {7'd0, rdata_oe}, 8'h00);
        idle();
    endtask

    task automatic t_read_no_write();
        @(negedge clk);
        sel_act_hi = 1'b1; sel_act_lo_n = 1'b0; mem_sel_n = 1'b1; rnw = 1'b1;
        addr = 7'h01; wdata = 8'h77;
        @(negedge clk); idle();
        check("R10 read with data leaves dir", p0_oe, 8'h12);
    endtask

    task automatic t_aux();
        logic [7:0] d; logic oe;
        @(negedge clk);
        sel_act_hi = 1'b1; sel_act_lo_n = 1'b0; mem_sel_n = 1'b1; rnw = 1'b0;
        addr = 7'h05; wdata = 8'hFF; #1;
        check("R9 aux_sel on sibling access", {7'd0, aux_sel}, 8'h01);
        @(negedge clk); idle();
        check("R9 sibling write leaves port0 dir", p0_oe, 8'h12);
        check("R9 sibling write leaves port1 out", p1_out, 8'h81);
        bus_read(1'b1, 7'h04, d, oe); check("R9 sibling read data", d, 8'h6B);
        #1; check("R1 aux_sel low when idle", {7'd0, aux_sel}, 8'h00);
    endtask

    task automatic t_reset_again();
        logic [7:0] d; logic oe;
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R6 pins inputs in reset", p0_oe | p1_oe, 8'h00);
        check("R6 out registers cleared", p0_out | p1_out, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        bus_read(1'b1, 7'h03, d, oe); check("R6 port1 dir cleared", d, 8'h00);
        bus_read(1'b0, 7'h55, d, oe); check("R8 ram kept over reset", d, 8'h96);
        bus_read(1'b0, 7'h00, d, oe); check("R8 ram byte 0 kept", d, 8'hA5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_ram();
        t_regs();
        t_sync();
        t_select();
        t_read_no_write();
        t_aux();
        t_reset_again();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired got=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule